// File: doc/BRIEF.md
# Alternating-Reload PWM Timer

This block is a 16-bit down-counting timer that produces a continuous pulse-width-modulated waveform once software has set it up. The main counter advances only on ticks of a clock-enable input, which stands for the already-prescaled clock chosen elsewhere. Each time the counter underflows, it takes its next value from one of two reload registers, A and B, in turn. When output toggling is enabled, the waveform output inverts on every underflow. The two reload values therefore set the length of one phase of the waveform and then the other.

The alternation always restarts at register A. This happens after reset, whenever PWM mode is off, and whenever the clock source is set to "no clock". Each reload sets a pending flag for the register it came from, and each flag drives its own interrupt behind its own enable. A second, independent down-counter with its own tick input wraps on underflow and raises a third pending flag and interrupt. Prescaler generation and bus decoding sit outside the block. Registers are written through plain write-enable and data ports.

Top module: `altpwm_timer`

## Requirements
- R1: While `mode_pwm` is 1, `clk1_off` is 0 and `tick1` is 1, `cnt1` decreases by one on the next clock edge (no write, not at zero). In every other case, with no write, `cnt1` holds its value.
- R2: An underflow is `cnt1` equal to 0x0000 on a counting tick. In place of wrapping, the counter loads a reload value on that edge. Successive underflows take register A, then B, then A, and so on.
- R3: The first reload after reset, and the first reload after `mode_pwm` rises, comes from register A. While `mode_pwm` is 0 the counter holds.
- R4: While `clk1_off` is 1 the counter holds and ticks are ignored. The first reload after `clk1_off` returns to 0 comes from register A.
- R5: A write on `cnt1_we` loads `cnt1_wdata` on the next edge and takes priority over counting and reload. Counting then continues from whatever value is held.
- R6: While `mode_pwm` is 0, `pwm_out` follows `init_lvl` one edge later. In mode, `pwm_out` inverts on every underflow when `tog_en` is 1 and holds when `tog_en` is 0. `pwm_out` is 0 after reset.
- R7: A reload from A sets `pend_a`, and a reload from B sets `pend_b`. The interrupt outputs are `irq_a = pend_a & ien_a` and `irq_b = pend_b & ien_b`.
- R8: A 1 on a clear strobe (`clr_a`, `clr_b`, `clr_2`) clears its pending flag on the next edge. If a set and a clear land in the same cycle, the flag ends set.
- R9: `cnt2` decreases on each `tick2`, regardless of mode. When it is 0x0000 on a tick it wraps to 0xFFFF and sets `pend_2`, and `irq_2 = pend_2 & ien_2`. A write on `cnt2_we` has priority over counting.
- R10: A write to a reload register takes effect for the next reload that uses that register. A reload in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pwm | input | 1 | PWM mode on; 0 holds counter 1 and restarts the A/B sequence |
| clk1_off | input | 1 | "No clock" selected for counter 1 |
| tick1 | input | 1 | Clock-enable for counter 1 |
| tick2 | input | 1 | Clock-enable for counter 2 |
| cnt1_we | input | 1 | Direct write strobe for counter 1 |
| cnt1_wdata | input | 16 | Counter 1 write value |
| rla_we | input | 1 | Reload A write strobe |
| rla_wdata | input | 16 | Reload A write value |
| rlb_we | input | 1 | Reload B write strobe |
| rlb_wdata | input | 16 | Reload B write value |
| cnt2_we | input | 1 | Direct write strobe for counter 2 |
| cnt2_wdata | input | 16 | Counter 2 write value |
| tog_en | input | 1 | Invert output on underflow |
| init_lvl | input | 1 | Output level used outside PWM mode |
| ien_a | input | 1 | Interrupt enable, reload A |
| ien_b | input | 1 | Interrupt enable, reload B |
| ien_2 | input | 1 | Interrupt enable, counter 2 |
| clr_a | input | 1 | Clear strobe for pend_a |
| clr_b | input | 1 | Clear strobe for pend_b |
| clr_2 | input | 1 | Clear strobe for pend_2 |
| cnt1 | output | 16 | Counter 1 value |
| cnt2 | output | 16 | Counter 2 value |
| pwm_out | output | 1 | Waveform output |
| pend_a | output | 1 | Reload-A pending flag |
| pend_b | output | 1 | Reload-B pending flag |
| pend_2 | output | 1 | Counter 2 underflow pending flag |
| irq_a | output | 1 | Interrupt, reload A |
| irq_b | output | 1 | Interrupt, reload B |
| irq_2 | output | 1 | Interrupt, counter 2 |

## Verification
The bench targets the points where the A/B sequence must restart.

- **Clock stop taken mid-sequence.** A design that forgot the restart would reload B where A is due, and the wrong count would show up at once.
- **Mode leave and re-entry.** This checks that the output falls back to the configured level. It also checks that the first reload is A, using a reload value rewritten while the mode was off; a stale value would show in the count.
- **Pending-flag clear in the underflow cycle.** A clear-wins flag would lose the event.
- **Counter write in the zero cycle.** A design without write priority would reload instead of loading the written value.
- **Long random run.** Writes, stops, mode changes and strobes are mixed over a long run and compared every cycle. This exposes an off-by-one in the decrement or in the wrap of the second counter.

// File: rtl/altpwm_pkg.sv
package altpwm_pkg;
  localparam int unsigned DEF_CNT_W = 16;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } reload_src_e;

  typedef enum int unsigned {
    FLG_A = 0,
    FLG_B = 1,
    FLG_2 = 2,
    FLG_NUM = 3
  } flag_idx_e;
endpackage

// File: rtl/altpwm_downcnt.sv
module altpwm_downcnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] rl_val,
  output logic [W-1:0] cnt,
  output logic         uflow
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  function automatic logic hits_zero(input logic tick, input logic wr,
                                     input logic [W-1:0] v);
    return tick && !wr && (v == ZERO);
  endfunction

  function automatic logic [W-1:0] next_val(input logic tick, input logic wr,
                                            input logic [W-1:0] v,
                                            input logic [W-1:0] wv,
                                            input logic [W-1:0] rv);
    if (wr)                   return wv;
    if (hits_zero(tick, wr, v)) return rv;
    if (tick)                 return v - ONE;
    return v;
  endfunction

  logic [W-1:0] cnt_q;

  assign uflow = hits_zero(en, ld, cnt_q);
  assign cnt   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= next_val(en, ld, cnt_q, ld_val, rl_val);
  end
endmodule

// File: rtl/altpwm_reload_seq.sv
module altpwm_reload_seq
  import altpwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         uflow,
  input  logic [W-1:0] rla,
  input  logic [W-1:0] rlb,
  output logic [W-1:0] rl_val,
  output reload_src_e  src,
  output logic         hit_a,
  output logic         hit_b
);
  reload_src_e src_q;

  function automatic reload_src_e other(input reload_src_e s);
    return (s == SRC_A) ? SRC_B : SRC_A;
  endfunction

  assign src    = src_q;
  assign rl_val = (src_q == SRC_A) ? rla : rlb;
  assign hit_a  = uflow && (src_q == SRC_A);
  assign hit_b  = uflow && (src_q == SRC_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_q <= SRC_A;
    else if (restart) src_q <= SRC_A;
    else if (uflow)   src_q <= other(src_q);
  end
endmodule

// File: rtl/altpwm_pend.sv
module altpwm_pend #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] pend,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set[i]) flag_q <= 1'b1;
      else if (clr[i]) flag_q <= 1'b0;
    end
    assign pend[i] = flag_q;
    assign irq[i]  = flag_q & ien[i];
  end
endmodule

// File: rtl/altpwm_timer.sv
module altpwm_timer
  import altpwm_pkg::*;
#(
  parameter int unsigned W = DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_pwm,
  input  logic         clk1_off,
  input  logic         tick1,
  input  logic         tick2,
  input  logic         cnt1_we,
  input  logic [W-1:0] cnt1_wdata,
  input  logic         rla_we,
  input  logic [W-1:0] rla_wdata,
  input  logic         rlb_we,
  input  logic [W-1:0] rlb_wdata,
  input  logic         cnt2_we,
  input  logic [W-1:0] cnt2_wdata,
  input  logic         tog_en,
  input  logic         init_lvl,
  input  logic         ien_a,
  input  logic         ien_b,
  input  logic         ien_2,
  input  logic         clr_a,
  input  logic         clr_b,
  input  logic         clr_2,
  output logic [W-1:0] cnt1,
  output logic [W-1:0] cnt2,
  output logic         pwm_out,
  output logic         pend_a,
  output logic         pend_b,
  output logic         pend_2,
  output logic         irq_a,
  output logic         irq_b,
  output logic         irq_2
);
  localparam int unsigned NF = int'(FLG_NUM);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] rla_q, rlb_q, rl_val;
  logic         run1, restart, uflow1, uflow2, hit_a, hit_b, pwm_q;
  reload_src_e  src;
  logic [NF-1:0] f_set, f_clr, f_ien, f_pend, f_irq;

  assign run1    = mode_pwm && !clk1_off && tick1;
  assign restart = !mode_pwm || clk1_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rla_q <= '0;
      rlb_q <= '0;
    end else begin
      if (rla_we) rla_q <= rla_wdata;
      if (rlb_we) rlb_q <= rlb_wdata;
    end
  end

  altpwm_reload_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .uflow(uflow1),
    .rla(rla_q), .rlb(rlb_q), .rl_val(rl_val), .src(src),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  altpwm_downcnt #(.W(W)) u_cnt1 (
    .clk(clk), .rst_n(rst_n), .en(run1), .ld(cnt1_we),
    .ld_val(cnt1_wdata), .rl_val(rl_val), .cnt(cnt1), .uflow(uflow1)
  );

  altpwm_downcnt #(.W(W)) u_cnt2 (
    .clk(clk), .rst_n(rst_n), .en(tick2), .ld(cnt2_we),
    .ld_val(cnt2_wdata), .rl_val(ALL_ONES), .cnt(cnt2), .uflow(uflow2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pwm_q <= 1'b0;
    else if (!mode_pwm)        pwm_q <= init_lvl;
    else if (uflow1 && tog_en) pwm_q <= ~pwm_q;
  end
  assign pwm_out = pwm_q;

  assign f_set[FLG_A] = hit_a;
  assign f_set[FLG_B] = hit_b;
  assign f_set[FLG_2] = uflow2;
  assign f_clr[FLG_A] = clr_a;
  assign f_clr[FLG_B] = clr_b;
  assign f_clr[FLG_2] = clr_2;
  assign f_ien[FLG_A] = ien_a;
  assign f_ien[FLG_B] = ien_b;
  assign f_ien[FLG_2] = ien_2;

  altpwm_pend #(.N(NF)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(f_set), .clr(f_clr), .ien(f_ien),
    .pend(f_pend), .irq(f_irq)
  );

  assign pend_a = f_pend[FLG_A];
  assign pend_b = f_pend[FLG_B];
  assign pend_2 = f_pend[FLG_2];
  assign irq_a  = f_irq[FLG_A];
  assign irq_b  = f_irq[FLG_B];
  assign irq_2  = f_irq[FLG_2];
endmodule

// File: rtl/altpwm_timer_chk.sv
module altpwm_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run1,
  input logic         restart,
  input logic         cnt1_we,
  input logic [W-1:0] cnt1_wdata,
  input logic [W-1:0] cnt1,
  input logic         uflow1,
  input logic         sel_b,
  input logic [W-1:0] rla_q,
  input logic [W-1:0] rlb_q,
  input logic         mode_pwm,
  input logic         tog_en,
  input logic         init_lvl,
  input logic         pwm_out,
  input logic         hit_a,
  input logic         hit_b,
  input logic         pend_a,
  input logic         pend_b,
  input logic         uflow2,
  input logic         pend_2,
  input logic [W-1:0] cnt2
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run1 && !cnt1_we && (cnt1 != '0) |=> cnt1 == $past(cnt1 - ONE));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run1 && !cnt1_we |=> $stable(cnt1));
  p_reload_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uflow1 && !sel_b |=> cnt1 == $past(rla_q));
  p_reload_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uflow1 && sel_b |=> cnt1 == $past(rlb_q));
  p_restart_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sel_b);
  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt1_we |=> cnt1 == $past(cnt1_wdata));
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pwm && uflow1 && tog_en |=> pwm_out != $past(pwm_out));
  p_idle_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pwm |=> pwm_out == $past(init_lvl));
  p_pend_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> pend_a);
  p_pend_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> pend_b);
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uflow2 |=> (cnt2 == '1) && pend_2);
endmodule

bind altpwm_timer altpwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run1(run1), .restart(restart),
  .cnt1_we(cnt1_we), .cnt1_wdata(cnt1_wdata), .cnt1(cnt1),
  .uflow1(uflow1), .sel_b(src == altpwm_pkg::SRC_B),
  .rla_q(rla_q), .rlb_q(rlb_q), .mode_pwm(mode_pwm), .tog_en(tog_en),
  .init_lvl(init_lvl), .pwm_out(pwm_out), .hit_a(hit_a), .hit_b(hit_b),
  .pend_a(pend_a), .pend_b(pend_b), .uflow2(uflow2), .pend_2(pend_2),
  .cnt2(cnt2)
);

// File: tb/altpwm_timer_bench.sv
`timescale 1ns/1ps
module altpwm_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_pwm = 0, clk1_off = 0, tick1 = 0, tick2 = 0;
  logic cnt1_we = 0, rla_we = 0, rlb_we = 0, cnt2_we = 0;
  logic [15:0] cnt1_wdata = 0, rla_wdata = 0, rlb_wdata = 0, cnt2_wdata = 0;
  logic tog_en = 0, init_lvl = 0, ien_a = 0, ien_b = 0, ien_2 = 0;
  logic clr_a = 0, clr_b = 0, clr_2 = 0;
  logic [15:0] cnt1, cnt2;
  logic pwm_out, pend_a, pend_b, pend_2, irq_a, irq_b, irq_2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_c1 = 0, m_c2 = 0, m_ra = 0, m_rb = 0;
  bit m_b = 0, m_pwm = 0, m_pa = 0, m_pb = 0, m_p2 = 0;

  always #5 clk = ~clk;

  altpwm_timer u_altpwm_timer (
    .clk(clk), .rst_n(rst_n), .mode_pwm(mode_pwm), .clk1_off(clk1_off),
    .tick1(tick1), .tick2(tick2), .cnt1_we(cnt1_we), .cnt1_wdata(cnt1_wdata),
    .rla_we(rla_we), .rla_wdata(rla_wdata), .rlb_we(rlb_we),
    .rlb_wdata(rlb_wdata), .cnt2_we(cnt2_we), .cnt2_wdata(cnt2_wdata),
    .tog_en(tog_en), .init_lvl(init_lvl), .ien_a(ien_a), .ien_b(ien_b),
    .ien_2(ien_2), .clr_a(clr_a), .clr_b(clr_b), .clr_2(clr_2),
    .cnt1(cnt1), .cnt2(cnt2), .pwm_out(pwm_out), .pend_a(pend_a),
    .pend_b(pend_b), .pend_2(pend_2), .irq_a(irq_a), .irq_b(irq_b),
    .irq_2(irq_2)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit run, uf, uf2, sa, sb;
    int nc1;
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; m_ra = 0; m_rb = 0;
      m_b = 0; m_pwm = 0; m_pa = 0; m_pb = 0; m_p2 = 0;
      return;
    end
    run = mode_pwm && !clk1_off && tick1;
    uf  = run && !cnt1_we && (m_c1 == 0);
    if (cnt1_we)  nc1 = int'(cnt1_wdata);
    else if (uf)  nc1 = m_b ? m_rb : m_ra;
    else if (run) nc1 = (m_c1 + 65535) % 65536;
    else          nc1 = m_c1;
    sa = uf && !m_b;
    sb = uf && m_b;
    if (!mode_pwm || clk1_off) m_b = 0;
    else if (uf)               m_b = !m_b;
    if (!mode_pwm)         m_pwm = init_lvl;
    else if (uf && tog_en) m_pwm = !m_pwm;
    m_pa = sa ? 1'b1 : (clr_a ? 1'b0 : m_pa);
    m_pb = sb ? 1'b1 : (clr_b ? 1'b0 : m_pb);
    uf2 = tick2 && !cnt2_we && (m_c2 == 0);
    m_p2 = uf2 ? 1'b1 : (clr_2 ? 1'b0 : m_p2);
    if (cnt2_we)    m_c2 = int'(cnt2_wdata);
    else if (uf2)   m_c2 = 65535;
    else if (tick2) m_c2 = m_c2 - 1;
    if (rla_we) m_ra = int'(rla_wdata);
    if (rlb_we) m_rb = int'(rlb_wdata);
    m_c1 = nc1;
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp("R2", "cnt1", int'(cnt1), m_c1);
    cmp("R6", "pwm_out", int'(pwm_out), int'(m_pwm));
    cmp("R7", "pend_a", int'(pend_a), int'(m_pa));
    cmp("R7", "pend_b", int'(pend_b), int'(m_pb));
    cmp("R7", "irq_a", int'(irq_a), int'(m_pa & ien_a));
    cmp("R7", "irq_b", int'(irq_b), int'(m_pb & ien_b));
    cmp("R9", "cnt2", int'(cnt2), m_c2);
    cmp("R9", "pend_2", int'(pend_2), int'(m_p2));
    cmp("R9", "irq_2", int'(irq_2), int'(m_p2 & ien_2));
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drop_strobes();
    cnt1_we = 0; rla_we = 0; rlb_we = 0; cnt2_we = 0;
    clr_a = 0; clr_b = 0; clr_2 = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step();
    rst_n = 1;
    cmp("R1", "reset cnt1", int'(cnt1), 0);
    cmp("R6", "reset pwm_out", int'(pwm_out), 0);
    cmp("R7", "reset pend_a", int'(pend_a), 0);

    // Set up: A=3, B=1, counter 2, output starts high.
    rla_we = 1; rla_wdata = 16'd3; rlb_we = 1; rlb_wdata = 16'd1;
    init_lvl = 1; tog_en = 1; ien_a = 1; ien_b = 1; ien_2 = 1;
    step(); drop_strobes();
    cmp("R6", "idle level", int'(pwm_out), 1);
    cnt1_we = 1; cnt1_wdata = 16'd2; mode_pwm = 1;
    step(); drop_strobes();
    cmp("R5", "direct write", int'(cnt1), 2);
    tick1 = 1;
    step();
    cmp("R1", "decrement", int'(cnt1), 1);
    steps(2);
    cmp("R3", "first reload from A", int'(cnt1), 3);
    cmp("R6", "toggle low", int'(pwm_out), 0);
    cmp("R7", "pend_a set", int'(pend_a), 1);
    cmp("R7", "irq_a", int'(irq_a), 1);
    steps(4);
    cmp("R2", "second reload from B", int'(cnt1), 1);
    cmp("R7", "pend_b set", int'(pend_b), 1);
    cmp("R6", "toggle high", int'(pwm_out), 1);
    steps(2);
    cmp("R2", "third reload from A", int'(cnt1), 3);

    // Clock stop while B is next.
    clk1_off = 1;
    steps(2);
    cmp("R4", "hold while stopped", int'(cnt1), 3);
    clk1_off = 0;
    steps(4);
    cmp("R4", "restart reloads A", int'(cnt1), 3);

    // Leave mode (B next), rewrite A, come back.
    mode_pwm = 0; init_lvl = 0;
    step();
    cmp("R6", "level outside mode", int'(pwm_out), 0);
    rla_we = 1; rla_wdata = 16'd5;
    step(); drop_strobes();
    cmp("R3", "hold outside mode", int'(cnt1), 3);
    mode_pwm = 1; tick1 = 0; cnt1_we = 1; cnt1_wdata = 16'd0;
    step(); drop_strobes();
    tick1 = 1;
    step();
    cmp("R10", "new A used after mode entry", int'(cnt1), 5);

    // Clear and set/clear collision.
    tick1 = 0; clr_a = 1;
    step(); drop_strobes();
    cmp("R8", "clear pend_a", int'(pend_a), 0);
    clr_b = 1;
    step(); drop_strobes();
    cmp("R8", "clear pend_b", int'(pend_b), 0);
    cnt1_we = 1; cnt1_wdata = 16'd0;
    step(); drop_strobes();
    tick1 = 1; clr_b = 1;
    step(); drop_strobes();
    cmp("R8", "set wins over clear", int'(pend_b), 1);
    cmp("R2", "B reload", int'(cnt1), 1);

    // Write in the zero cycle wins over reload.
    steps(1);
    cnt1_we = 1; cnt1_wdata = 16'h0040;
    step(); drop_strobes();
    cmp("R5", "write beats reload", int'(cnt1), 16'h0040);

    // No toggle when disabled.
    tog_en = 0; cnt1_we = 1; cnt1_wdata = 16'd0;
    step(); drop_strobes();
    begin
      int lvl;
      lvl = int'(pwm_out);
      steps(3);
      cmp("R6", "no toggle when disabled", int'(pwm_out), lvl);
    end

    // Counter 2.
    tick1 = 0; cnt2_we = 1; cnt2_wdata = 16'd2;
    step(); drop_strobes();
    tick2 = 1;
    steps(3);
    cmp("R9", "wrap to all ones", int'(cnt2), 16'hFFFF);
    cmp("R9", "irq_2", int'(irq_2), 1);
    tick2 = 0;

    // Mixed random traffic.
    for (int i = 0; i < 4000; i++) begin
      mode_pwm   = ($urandom % 20) != 0;
      clk1_off   = ($urandom % 16) == 0;
      tick1      = ($urandom % 3) != 0;
      tick2      = ($urandom % 2) != 0;
      cnt1_we    = ($urandom % 25) == 0;
      cnt1_wdata = 16'($urandom % 9);
      rla_we     = ($urandom % 30) == 0;
      rla_wdata  = 16'($urandom % 7);
      rlb_we     = ($urandom % 30) == 0;
      rlb_wdata  = 16'($urandom % 7);
      cnt2_we    = ($urandom % 40) == 0;
      cnt2_wdata = 16'($urandom % 12);
      tog_en     = ($urandom % 8) != 0;
      init_lvl   = 1'($urandom);
      ien_a = 1'($urandom); ien_b = 1'($urandom); ien_2 = 1'($urandom);
      clr_a = ($urandom % 4) == 0;
      clr_b = ($urandom % 4) == 0;
      clr_2 = ($urandom % 4) == 0;
      step();
    end
    drop_strobes();
    done = 1;
    finish_run();
  end
endmodule